// File: doc/BRIEF.md
# Scan Test Access Port Controller

This block is the serial test port of a synchronous memory device. A 16-state controller, clocked by the test clock and steered by the mode-select input, walks the standard capture, shift and update sequences for an instruction path and a data path. It holds a 3-bit instruction, a 1-bit pass-through register and a 32-bit identification register. The active instruction chooses which data register sits between the serial input and the serial output.

The boundary cells around the device pins live outside this block. The block drives them with capture, shift and update strobes. It also raises a flag while the boundary should drive the pins (external test), and a second flag while every data output must float (sample with outputs off). The boundary chain takes its serial input straight from `tdi`. It returns its last cell on `bsrTdo`.

The inputs are sampled on the rising edge of `tck`. The serial output and the active instruction change on the falling edge. An active-low asynchronous reset forces the controller into its reset state. Five rising edges with `tms` high do the same.

Top module: `scan_port`

## Requirements
- R1: While `trstN` is low, the controller is held in its reset state and the active instruction is the identification opcode 001. The reset takes effect at once and does not wait for a clock edge. It clears `testMode`, `outputsFloat`, `bsrSel` and `tdoEn`.
- R2: In the capture-instruction state the instruction shift register loads 001. The first bit shifted out (on `tdo`) is therefore 1, then 0, then 0. Instruction bits shift in and out least significant bit first.
- R3: With the identification opcode 001 active, a data scan first shifts out the 32-bit value 0x000101B3, least significant bit first. It then returns the bits shifted in on `tdi`, delayed by 32 clocks.
- R4: Opcode 111 selects the 1-bit pass-through register. It captures 0, so a data scan returns 0 first and then `tdi` delayed by one clock.
- R5: The unused opcodes 011, 101 and 110 behave exactly like 111. They select the pass-through register and keep `bsrSel`, `testMode` and `outputsFloat` low.
- R6: Opcodes 000 (external test), 100 (sample) and 010 (sample with outputs off) select the boundary chain: `bsrSel` is high and `tdo` follows `bsrTdo` during a data shift. `testMode` is high only for 000, and `outputsFloat` is high only for 010.
- R7: One data scan with the boundary chain selected gives exactly one `bsrCapture` cycle, one `bsrUpdate` cycle, and one `bsrShift` cycle per shifted bit. When another register is selected, all three strobes stay low.
- R8: Five consecutive rising edges with `tms` high, from any state, reach the reset state. The active instruction then becomes 001.
- R9: `tdoEn` is high only while the controller is in a shift state, and `tdo` is 0 whenever `tdoEn` is low.
- R10: A newly shifted instruction becomes active only on the falling edge in the update-instruction state. Until then the outputs keep the previous instruction's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in (also feeds the boundary chain) |
| bsrTdo | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdoEn | output | 1 | High while `tdo` carries shift data |
| bsrCapture | output | 1 | Boundary chain capture strobe |
| bsrShift | output | 1 | Boundary chain shift strobe |
| bsrUpdate | output | 1 | Boundary chain update strobe |
| bsrSel | output | 1 | Boundary chain is the selected data register |
| testMode | output | 1 | Boundary cells drive the pins (external test) |
| outputsFloat | output | 1 | All data outputs forced off |

## Verification
The assertions check four things on every clock edge:
- the capture value of the instruction register and of the pass-through register;
- that `tdoEn` is only high in shift states;
- that the active instruction never changes outside the update-instruction and reset states;
- that five high `tms` edges always end in the reset state.

Only the bench's scenarios can show end-to-end behaviour:
- the identification value and the serial delay through each data register;
- how each opcode maps to a register and to the two pin flags;
- the strobe counts per scan;
- the recovery from an asynchronous reset in the middle of an operation.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
  localparam int IR_W = 3;
  typedef logic [IR_W-1:0] opcode_t;

  localparam opcode_t OP_EXTEST = 3'b000;
  localparam opcode_t OP_SAMPLE = 3'b100;
  localparam opcode_t OP_IDCODE = 3'b001;
  localparam opcode_t OP_SAMPLZ = 3'b010;
  localparam opcode_t OP_BYPASS = 3'b111;
  localparam opcode_t IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_t;

  typedef enum logic [1:0] {SEL_BSR, SEL_ID, SEL_BYP} drSel_t;

  typedef struct packed {
    logic tlr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobes_t;

  function automatic drSel_t decodeSel(opcode_t op);
    case (op)
      OP_EXTEST, OP_SAMPLE, OP_SAMPLZ: decodeSel = SEL_BSR;
      OP_IDCODE:                       decodeSel = SEL_ID;
      default:                         decodeSel = SEL_BYP;
    endcase
  endfunction
endpackage

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tms,
  output tapStrobes_t strb
);
  tapState_t state, nextState;

  always_comb begin
    case (state)
      ST_TLR:    nextState = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nextState = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SHF_IR;
      default:   nextState = tms ? ST_SEL_DR : ST_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_TLR;
    else        state <= nextState;
  end

  always_comb begin
    strb.tlr       = (state == ST_TLR);
    strb.captureIr = (state == ST_CAP_IR);
    strb.shiftIr   = (state == ST_SHF_IR);
    strb.updateIr  = (state == ST_UPD_IR);
    strb.captureDr = (state == ST_CAP_DR);
    strb.shiftDr   = (state == ST_SHF_DR);
    strb.updateDr  = (state == ST_UPD_DR);
  end

  // run of consecutive high tms edges, for the reset property
  logic [2:0] onesCnt;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                  onesCnt <= '0;
    else if (!tms)               onesCnt <= '0;
    else if (onesCnt != 3'd7)    onesCnt <= onesCnt + 3'd1;
  end

  // R8: fifth consecutive high tms edge lands in the reset state
  a_r8_tms_reset: assert property (@(posedge tck) disable iff (!trstN)
    (tms && onesCnt >= 3'd4) |=> (state == ST_TLR));
endmodule

// File: rtl/scan_port_dpath.sv
module scan_port_dpath
  import scan_port_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h000101B3
) (
  input  logic        tck,
  input  logic        trstN,
  input  logic        tdi,
  input  logic        bsrTdo,
  input  tapStrobes_t strb,
  output opcode_t     activeIr,
  output drSel_t      sel,
  output logic        tdo,
  output logic        tdoEn
);
  opcode_t         irShift;
  logic            bypassBit;
  logic [ID_W-1:0] idReg;

  assign sel = decodeSel(activeIr);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              irShift <= IR_CAPTURE;
    else if (strb.captureIr) irShift <= IR_CAPTURE;
    else if (strb.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bypassBit <= 1'b0;
    else if (sel == SEL_BYP) begin
      if (strb.captureDr)    bypassBit <= 1'b0;
      else if (strb.shiftDr) bypassBit <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) idReg <= ID_VALUE[ID_W-1:0];
    else if (sel == SEL_ID) begin
      if (strb.captureDr)    idReg <= ID_VALUE[ID_W-1:0];
      else if (strb.shiftDr) idReg <= {tdi, idReg[ID_W-1:1]};
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)             activeIr <= OP_IDCODE;
    else if (strb.tlr)      activeIr <= OP_IDCODE;
    else if (strb.updateIr) activeIr <= irShift;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else if (strb.shiftIr) begin
      tdo   <= irShift[0];
      tdoEn <= 1'b1;
    end else if (strb.shiftDr) begin
      tdoEn <= 1'b1;
      case (sel)
        SEL_BSR: tdo <= bsrTdo;
        SEL_ID:  tdo <= idReg[0];
        default: tdo <= bypassBit;
      endcase
    end else begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end
  end

  // R2: instruction capture pattern
  a_r2_ir_capture: assert property (@(posedge tck) disable iff (!trstN)
    strb.captureIr |=> (irShift == IR_CAPTURE));
  // R4: pass-through register captures zero
  a_r4_bypass_zero: assert property (@(posedge tck) disable iff (!trstN)
    (strb.captureDr && sel == SEL_BYP) |=> (bypassBit == 1'b0));
  // R9: serial output enabled only in shift states
  a_r9_tdo_en_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (strb.shiftIr || strb.shiftDr));
  // R10: active instruction changes only in update-IR or reset
  a_r10_ir_hold: assert property (@(negedge tck) disable iff (!trstN)
    !(strb.updateIr || strb.tlr) |=> $stable(activeIr));
endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_port_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h000101B3
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  input  logic bsrTdo,
  output logic tdo,
  output logic tdoEn,
  output logic bsrCapture,
  output logic bsrShift,
  output logic bsrUpdate,
  output logic bsrSel,
  output logic testMode,
  output logic outputsFloat
);
  tapStrobes_t strb;
  opcode_t     activeIr;
  drSel_t      sel;

  scan_port_ctrl i_ctrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .strb  (strb)
  );

  scan_port_dpath #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) i_dpath (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .bsrTdo   (bsrTdo),
    .strb     (strb),
    .activeIr (activeIr),
    .sel      (sel),
    .tdo      (tdo),
    .tdoEn    (tdoEn)
  );

  assign bsrSel       = (sel == SEL_BSR);
  assign bsrCapture   = bsrSel && strb.captureDr;
  assign bsrShift     = bsrSel && strb.shiftDr;
  assign bsrUpdate    = bsrSel && strb.updateDr;
  assign testMode     = (activeIr == OP_EXTEST);
  assign outputsFloat = (activeIr == OP_SAMPLZ);
endmodule

// File: tb/test_scan_port.sv
module test_scan_port;
  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsrTdo = 1'b0;
  logic tdo, tdoEn, bsrCapture, bsrShift, bsrUpdate, bsrSel, testMode, outputsFloat;

  int checks = 0;
  int errors = 0;
  int capCnt, shfCnt, updCnt;
  int enBad = 0;
  logic inShift = 1'b0;
  logic done = 1'b0;

  localparam logic [31:0] EXP_ID = 32'b0000_0000_0000_0001_0000_0001_1011_0011;

  always #10 tck = ~tck;

  scan_port i_scan_port (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .bsrTdo(bsrTdo),
    .tdo(tdo), .tdoEn(tdoEn), .bsrCapture(bsrCapture), .bsrShift(bsrShift),
    .bsrUpdate(bsrUpdate), .bsrSel(bsrSel), .testMode(testMode),
    .outputsFloat(outputsFloat)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one test clock: sample outputs after the falling edge, then drive inputs
  task automatic step(input logic m, input logic d, output logic sTdo);
    @(negedge tck);
    #2;
    sTdo = tdo;
    if (tdoEn !== inShift) enBad++;
    if (!tdoEn && tdo !== 1'b0) enBad++;
    capCnt += int'(bsrCapture);
    shfCnt += int'(bsrShift);
    updCnt += int'(bsrUpdate);
    tms = m;
    tdi = d;
  endtask

  task automatic scanIr(input logic [2:0] op, output logic [2:0] irOut);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    inShift = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i], o);
      irOut[i] = o;
    end
    inShift = 1'b0;
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, input logic [63:0] pat,
                        output logic [63:0] dout);
    logic o;
    dout = '0;
    capCnt = 0; shfCnt = 0; updCnt = 0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    inShift = 1'b1;
    for (int i = 0; i < n; i++) begin
      bsrTdo = pat[i];
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    inShift = 1'b0;
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [2:0]  irOut;
    logic [63:0] dout;
    logic        o;
    logic [2:0]  unusedOps [3];
    logic [2:0]  bsrOps [3];
    unusedOps = '{3'b011, 3'b101, 3'b110};
    bsrOps    = '{3'b000, 3'b100, 3'b010};

    // R1: reset state
    repeat (3) @(posedge tck);
    #3;
    check("R1 tdoEn in reset", 64'(tdoEn), 64'd0);
    check("R1 testMode in reset", 64'(testMode), 64'd0);
    check("R1 outputsFloat in reset", 64'(outputsFloat), 64'd0);
    check("R1 bsrSel in reset", 64'(bsrSel), 64'd0);
    @(negedge tck); #2; trstN = 1'b1;
    step(0, 0, o);

    // R3: identification value, then tdi delayed by 32 clocks
    scanDr(64, 64'h1234_5678_9ABC_DEF0, '0, dout);
    check("R3 id value", dout[31:0], 64'(EXP_ID));
    check("R3 id shift-through", dout[63:32], 64'h9ABC_DEF0);

    // R2: instruction capture pattern 001
    scanIr(3'b111, irOut);
    check("R2 ir capture", 64'(irOut), 64'b001);

    // R4: pass-through register, full sweep over 8-bit patterns
    for (int p = 0; p < 256; p++) begin
      scanDr(8, 64'(p), '0, dout);
      check("R4 bypass delay", dout[7:0], 64'({p[6:0], 1'b0}));
    end
    check("R7 no strobes on bypass", 64'(capCnt + shfCnt + updCnt), 64'd0);

    // R5: unused opcodes act as pass-through
    foreach (unusedOps[k]) begin
      scanIr(unusedOps[k], irOut);
      check("R5 bsrSel", 64'(bsrSel), 64'd0);
      check("R5 testMode", 64'(testMode), 64'd0);
      check("R5 outputsFloat", 64'(outputsFloat), 64'd0);
      scanDr(12, 64'hA5C, 64'hFFF, dout);
      check("R5 bypass path", dout[11:0], 64'h4B8);
    end

    // R6 / R7: boundary instructions
    foreach (bsrOps[k]) begin
      scanIr(bsrOps[k], irOut);
      check("R6 bsrSel", 64'(bsrSel), 64'd1);
      check("R6 testMode", 64'(testMode), 64'(bsrOps[k] == 3'b000));
      check("R6 outputsFloat", 64'(outputsFloat), 64'(bsrOps[k] == 3'b010));
      scanDr(20, 64'h0, 64'(20'hB3C5A ^ (k * 20'h11111)), dout);
      check("R6 tdo follows boundary", dout[19:0], 64'(20'hB3C5A ^ (k * 20'h11111)));
      check("R7 capture count", 64'(capCnt), 64'd1);
      check("R7 shift count", 64'(shfCnt), 64'd20);
      check("R7 update count", 64'(updCnt), 64'd1);
    end

    // R7: identification selected gives no boundary strobes
    scanIr(3'b001, irOut);
    scanDr(32, '0, '0, dout);
    check("R7 no strobes on id", 64'(capCnt + shfCnt + updCnt), 64'd0);
    check("R3 id after reload", dout[31:0], 64'(EXP_ID));

    // R10: new instruction waits for update-IR
    scanIr(3'b000, irOut);
    check("R10 extest active", 64'(testMode), 64'd1);
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    inShift = 1'b1;
    for (int i = 0; i < 3; i++) step(i == 2, 3'b100 >> i, o);
    inShift = 1'b0;
    step(1, 0, o);
    check("R10 held in exit1-IR", 64'(testMode), 64'd1);
    step(0, 0, o);
    check("R10 applied in update-IR", 64'(testMode), 64'd0);
    check("R10 sample selects boundary", 64'(bsrSel), 64'd1);

    // R8: five high tms edges from shift-DR
    scanIr(3'b111, irOut);
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    inShift = 1'b1;
    step(1, 0, o);
    inShift = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 0, o);
    step(0, 0, o);
    scanDr(32, '0, '0, dout);
    check("R8 id after tms reset", dout[31:0], 64'(EXP_ID));

    // R1: asynchronous reset mid-operation
    scanIr(3'b000, irOut);
    check("R1 extest before reset", 64'(testMode), 64'd1);
    step(1, 0, o);
    #3; trstN = 1'b0;
    #1;
    check("R1 async clears testMode", 64'(testMode), 64'd0);
    check("R1 async clears bsrSel", 64'(bsrSel), 64'd0);
    @(negedge tck); #2; trstN = 1'b1; tms = 1'b0;
    step(0, 0, o);
    scanDr(32, '0, '0, dout);
    check("R1 id after async reset", dout[31:0], 64'(EXP_ID));

    // R9: enable only in shift states, tdo quiet otherwise
    check("R9 enable and idle tdo", 64'(enBad), 64'd0);

    done = 1'b1;
    finishRun();
  end
endmodule